// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide register front end of a classic eight-line programmable interrupt controller. Software reaches it through two addresses. On address 0 it accepts the start of an initialization sequence and two kinds of run-time commands: end-of-interrupt and rotation commands, and read-control commands. On address 1 it accepts the remaining initialization bytes, and when no sequence is in progress it accepts the interrupt mask. The block holds the mask, the in-service register, the rotation base that sets the priority order, the vector base and the mode flags. Reads return the pending-request vector, the in-service register, the mask or a poll result.

Request capture and the winner search for delivery sit in sibling blocks. This block takes the pending-request vector, the current poll winner and a line acknowledge from those siblings. It searches its own in-service register in rotated priority order to carry out non-specific end-of-interrupt commands. When an initialization sequence starts, it emits a one-cycle pulse so that the request latch flushes.

Top module: `intc_cmd_decoder`

## Requirements
- R1: After reset the mask, in-service register, rotation base, vector base and every mode flag are zero, no initialization is in progress, and `rdata` is zero while `rd_en` is low.
- R2: An address-0 write with bit 4 set starts initialization at the vector step. It clears the mask, the in-service register, the rotation base, special mask, the nested and auto-EOI flags, the rotate-on-auto-EOI flag, the poll flag and read select (IRR). It latches single mode from bit 1 and fourth-byte-needed from bit 0, and pulses `irr_flush` for one cycle. If bit 3 is also set, `level_unsup` pulses for one cycle.
- R3: At the vector step, an address-1 write sets the vector base to the data with its low three bits cleared. The sequence then goes to the cascade step when not in single mode, to the mode step when single and the fourth byte is needed, and otherwise ends.
- R4: At the cascade step, an address-1 write moves to the mode step if the fourth byte is needed, and otherwise ends the sequence.
- R5: At the mode step, an address-1 write sets nested mode from bit 4 and auto-EOI from bit 1, then ends the sequence.
- R6: With no sequence in progress, an address-1 write loads the mask and an address-1 read returns it.
- R7: An address-0 write with bit 4 clear and bit 3 set is a read-control command. If bit 1 is set, bit 0 selects which register address-0 reads return (1 = ISR, 0 = IRR). Bits 6:5 equal to 3 set special mask, equal to 2 clear it, and any other value leaves it unchanged.
- R8: A read-control command with bit 2 set arms a poll. The next address-0 read returns 0x80 OR the winning line when a winner exists, and 0x00 otherwise, and it disarms the poll. Later reads follow read select again.
- R9: A line acknowledge sets that line's in-service bit when auto-EOI is off. When auto-EOI is on, the in-service register is unchanged, and the rotation base becomes line+1 mod 8 if rotate-on-auto-EOI is set.
- R10: An address-0 write with bits 4 and 3 clear is an EOI/rotation command, with the opcode in bits 7:5. Opcode 1 clears the highest-priority in-service bit, where the priority order starts at the rotation base and rises mod 8. Opcode 5 does the same and also sets the rotation base to that line+1.
- R11: Opcode 3 clears the in-service bit named by data bits 2:0. Opcode 7 clears that bit and sets the rotation base to line+1. Opcode 6 sets the rotation base to data bits 2:0 plus 1 mod 8. Opcode 2 changes nothing.
- R12: Opcode 0 clears rotate-on-auto-EOI and opcode 4 sets it.
- R13: Opcode 1 or 5 with an empty in-service register changes neither the in-service register nor the rotation base.
- R14: While a sequence is in progress, address-1 writes leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 1 | Register address (0 or 1) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational, zero when not reading |
| irr_in | input | 8 | Pending-request vector from the request latch |
| poll_valid | input | 1 | A winning request exists |
| poll_line | input | 3 | Winning line from the priority search |
| ack_valid | input | 1 | Line acknowledge strobe |
| ack_line | input | 3 | Acknowledged line |
| imr | output | 8 | Interrupt mask |
| isr | output | 8 | In-service register |
| rot_base | output | 3 | Rotation base (line with highest priority) |
| vec_base | output | 8 | Vector base |
| init_busy | output | 1 | Initialization sequence in progress |
| single_mode | output | 1 | Single (non-cascaded) mode |
| nested_mode | output | 1 | Special fully nested mode |
| auto_eoi | output | 1 | Automatic EOI mode |
| special_mask | output | 1 | Special mask mode |
| rot_on_aeoi | output | 1 | Rotate on automatic EOI |
| irr_flush | output | 1 | One-cycle pulse telling the request latch to clear |
| level_unsup | output | 1 | One-cycle pulse: unsupported level mode was requested |

## Verification
The hardest case to reach is a non-specific end-of-interrupt under a rotated priority order. It needs several in-service bits set at once and a rotation base that is not zero, so that the winner differs from the lowest-numbered bit. The bench builds that state by acknowledging lines 2, 5 and 6, moves the base to 6 with a set-base command, and then issues a rotating non-specific EOI. The expected result is that line 6, not line 5, is cleared and the base moves to 7. The cascade and mode steps of initialization are reached only through specific first-byte flag combinations, so each combination gets its own sequence.

// File: rtl/icd_pkg.sv
package icd_pkg;

   typedef enum logic [1:0] {
      STEP_IDLE    = 2'd0,
      STEP_VECTOR  = 2'd1,
      STEP_CASCADE = 2'd2,
      STEP_MODE    = 2'd3
   } init_step_e;

   // Opcode values are fixed by the command byte encoding (bits 7:5)
   typedef enum logic [2:0] {
      OP_RAEOI_OFF  = 3'd0,
      OP_EOI_ANY    = 3'd1,
      OP_NOP        = 3'd2,
      OP_EOI_LINE   = 3'd3,
      OP_RAEOI_ON   = 3'd4,
      OP_EOI_ANYROT = 3'd5,
      OP_SET_BASE   = 3'd6,
      OP_EOI_LROT   = 3'd7
   } cmd_op_e;

endpackage

// File: rtl/icd_rot_pick.sv
// Rotated find-first: the lowest offset from base whose bit is set wins.
module icd_rot_pick #(
   parameter int N_LINES = 8,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] req,
   input  logic [LW-1:0]      base,
   output logic               found,
   output logic [LW-1:0]      line
);

   if ((1 << LW) != N_LINES || N_LINES < 2) begin : g_bad_lines
      $error("icd_rot_pick: N_LINES must be a power of two, at least 2");
   end

   logic [N_LINES-1:0] rot;

   for (genvar k = 0; k < N_LINES; k++) begin : g_rot
      logic [LW-1:0] idx;
      assign idx    = base + LW'(k);
      assign rot[k] = req[idx];
   end

   always_comb begin
      found = 1'b0;
      line  = '0;
      for (int k = N_LINES - 1; k >= 0; k--) begin
         if (rot[k]) begin
            found = 1'b1;
            line  = base + LW'(k);
         end
      end
   end

endmodule

// File: rtl/icd_init_seq.sv
module icd_init_seq
   import icd_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int LINE_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_we,
   input  logic              data_we,
   input  logic [DATA_W-1:0] wdata,
   output logic              busy,
   output logic [DATA_W-1:0] vec_base,
   output logic              single_mode,
   output logic              nested_mode,
   output logic              auto_eoi
);

   localparam logic [DATA_W-1:0] VEC_MASK = {DATA_W{1'b1}} << LINE_W;

   init_step_e step_q;
   logic       need4_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         step_q      <= STEP_IDLE;
         need4_q     <= 1'b0;
         single_mode <= 1'b0;
         vec_base    <= '0;
         nested_mode <= 1'b0;
         auto_eoi    <= 1'b0;
      end else if (start_we) begin
         step_q      <= STEP_VECTOR;
         need4_q     <= wdata[0];
         single_mode <= wdata[1];
         nested_mode <= 1'b0;
         auto_eoi    <= 1'b0;
      end else if (data_we) begin
         case (step_q)
            STEP_VECTOR: begin
               vec_base <= wdata & VEC_MASK;
               if (!single_mode)  step_q <= STEP_CASCADE;
               else if (need4_q)  step_q <= STEP_MODE;
               else               step_q <= STEP_IDLE;
            end
            STEP_CASCADE: step_q <= need4_q ? STEP_MODE : STEP_IDLE;
            STEP_MODE: begin
               nested_mode <= wdata[4];
               auto_eoi    <= wdata[1];
               step_q      <= STEP_IDLE;
            end
            default: ;
         endcase
      end
   end

   assign busy = (step_q != STEP_IDLE);

   assert_start_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_we |=> step_q == STEP_VECTOR);

   assert_vector_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !start_we && step_q == STEP_VECTOR)
      |=> vec_base == ($past(wdata) & VEC_MASK));

   assert_cascade_next_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !start_we && step_q == STEP_CASCADE)
      |=> step_q == ($past(need4_q) ? STEP_MODE : STEP_IDLE));

   assert_mode_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (data_we && !start_we && step_q == STEP_MODE)
      |=> (step_q == STEP_IDLE) && (auto_eoi == $past(wdata[1])));

endmodule

// File: rtl/icd_isr_ctl.sv
module icd_isr_ctl
   import icd_pkg::*;
#(
   parameter int N_LINES = 8,
   localparam int LW = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               init_clr,
   input  logic               ack_valid,
   input  logic [LW-1:0]      ack_line,
   input  logic               auto_eoi,
   input  logic               cmd_we,
   input  cmd_op_e            cmd_op,
   input  logic [LW-1:0]      cmd_line,
   output logic [N_LINES-1:0] isr,
   output logic [LW-1:0]      rot_base,
   output logic               rot_on_aeoi
);

   logic [N_LINES-1:0] isr_q, isr_n;
   logic [LW-1:0]      base_q, base_n;
   logic               rae_q, rae_n;
   logic               top_found;
   logic [LW-1:0]      top_line;

   icd_rot_pick #(.N_LINES(N_LINES)) u_pick (
      .req   (isr_q),
      .base  (base_q),
      .found (top_found),
      .line  (top_line)
   );

   always_comb begin
      isr_n  = isr_q;
      base_n = base_q;
      rae_n  = rae_q;
      if (ack_valid) begin
         if (!auto_eoi)    isr_n[ack_line] = 1'b1;
         else if (rae_q)   base_n = ack_line + LW'(1);
      end
      if (cmd_we) begin
         case (cmd_op)
            OP_RAEOI_OFF, OP_RAEOI_ON: rae_n = cmd_op[2];
            OP_EOI_ANY: if (top_found) isr_n[top_line] = 1'b0;
            OP_EOI_ANYROT: if (top_found) begin
               isr_n[top_line] = 1'b0;
               base_n          = top_line + LW'(1);
            end
            OP_EOI_LINE: isr_n[cmd_line] = 1'b0;
            OP_SET_BASE: base_n = cmd_line + LW'(1);
            OP_EOI_LROT: begin
               isr_n[cmd_line] = 1'b0;
               base_n          = cmd_line + LW'(1);
            end
            default: ;
         endcase
      end
      if (init_clr) begin
         isr_n  = '0;
         base_n = '0;
         rae_n  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         isr_q  <= '0;
         base_q <= '0;
         rae_q  <= 1'b0;
      end else begin
         isr_q  <= isr_n;
         base_q <= base_n;
         rae_q  <= rae_n;
      end
   end

   assign isr         = isr_q;
   assign rot_base    = base_q;
   assign rot_on_aeoi = rae_q;

   assert_ack_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && !auto_eoi && !cmd_we && !init_clr)
      |=> isr_q[$past(ack_line)]);

   assert_eoi_line_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_op == OP_EOI_LINE && !init_clr)
      |=> !isr_q[$past(cmd_line)]);

   assert_eoi_empty_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && (cmd_op == OP_EOI_ANY || cmd_op == OP_EOI_ANYROT)
       && isr_q == '0 && !ack_valid && !init_clr)
      |=> (isr_q == '0) && $stable(base_q));

endmodule

// File: rtl/intc_cmd_decoder.sv
module intc_cmd_decoder
   import icd_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int NUM_LINES = 8,
   localparam int LW       = $clog2(NUM_LINES)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 rd_en,
   input  logic                 addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic [DATA_W-1:0]    rdata,
   input  logic [NUM_LINES-1:0] irr_in,
   input  logic                 poll_valid,
   input  logic [LW-1:0]        poll_line,
   input  logic                 ack_valid,
   input  logic [LW-1:0]        ack_line,
   output logic [NUM_LINES-1:0] imr,
   output logic [NUM_LINES-1:0] isr,
   output logic [LW-1:0]        rot_base,
   output logic [DATA_W-1:0]    vec_base,
   output logic                 init_busy,
   output logic                 single_mode,
   output logic                 nested_mode,
   output logic                 auto_eoi,
   output logic                 special_mask,
   output logic                 rot_on_aeoi,
   output logic                 irr_flush,
   output logic                 level_unsup
);

   if (DATA_W < 8) begin : g_bad_width
      $error("intc_cmd_decoder: command fields need DATA_W of at least 8");
   end
   if (NUM_LINES > 8 || NUM_LINES < 2 || (1 << LW) != NUM_LINES) begin : g_bad_lines
      $error("intc_cmd_decoder: NUM_LINES must be 2, 4 or 8");
   end

   // Command byte decode
   logic    wr0, wr1, rd0;
   logic    start_we, rctl_we, cmd_we;
   cmd_op_e cmd_op;

   assign wr0      = wr_en && (addr == 1'b0);
   assign wr1      = wr_en && (addr == 1'b1);
   assign rd0      = rd_en && (addr == 1'b0);
   assign start_we = wr0 &&  wdata[4];
   assign rctl_we  = wr0 && !wdata[4] &&  wdata[3];
   assign cmd_we   = wr0 && !wdata[4] && !wdata[3];
   assign cmd_op   = cmd_op_e'(wdata[7:5]);

   icd_init_seq #(.DATA_W(DATA_W), .LINE_W(LW)) u_init (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_we    (start_we),
      .data_we     (wr1),
      .wdata       (wdata),
      .busy        (init_busy),
      .vec_base    (vec_base),
      .single_mode (single_mode),
      .nested_mode (nested_mode),
      .auto_eoi    (auto_eoi)
   );

   icd_isr_ctl #(.N_LINES(NUM_LINES)) u_isr (
      .clk         (clk),
      .rst_n       (rst_n),
      .init_clr    (start_we),
      .ack_valid   (ack_valid),
      .ack_line    (ack_line),
      .auto_eoi    (auto_eoi),
      .cmd_we      (cmd_we),
      .cmd_op      (cmd_op),
      .cmd_line    (wdata[LW-1:0]),
      .isr         (isr),
      .rot_base    (rot_base),
      .rot_on_aeoi (rot_on_aeoi)
   );

   // Mask, read control and pulses
   logic read_isr_q, poll_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         imr          <= '0;
         read_isr_q   <= 1'b0;
         poll_q       <= 1'b0;
         special_mask <= 1'b0;
         irr_flush    <= 1'b0;
         level_unsup  <= 1'b0;
      end else begin
         irr_flush   <= start_we;
         level_unsup <= start_we && wdata[3];
         if (start_we) begin
            imr          <= '0;
            read_isr_q   <= 1'b0;
            poll_q       <= 1'b0;
            special_mask <= 1'b0;
         end else begin
            if (wr1 && !init_busy) imr <= wdata[NUM_LINES-1:0];
            if (rd0 && poll_q)     poll_q <= 1'b0;
            if (rctl_we) begin
               if (wdata[2]) poll_q       <= 1'b1;
               if (wdata[1]) read_isr_q   <= wdata[0];
               if (wdata[6]) special_mask <= wdata[5];
            end
         end
      end
   end

   always_comb begin
      rdata = '0;
      if (rd_en) begin
         if (addr) begin
            rdata[NUM_LINES-1:0] = imr;
         end else if (poll_q) begin
            rdata[DATA_W-1] = poll_valid;
            if (poll_valid) rdata[LW-1:0] = poll_line;
         end else if (read_isr_q) begin
            rdata[NUM_LINES-1:0] = isr;
         end else begin
            rdata[NUM_LINES-1:0] = irr_in;
         end
      end
   end

   assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start_we |=> (imr == '0) && (isr == '0) && (rot_base == '0) && irr_flush);

   assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && !init_busy) |=> imr == $past(wdata[NUM_LINES-1:0]));

   assert_read_select_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rctl_we && wdata[1]) |=> read_isr_q == $past(wdata[0]));

   assert_poll_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd0 && poll_q && !wr_en) |=> !poll_q);

   assert_mask_hold_R14: assert property (@(posedge clk) disable iff (!rst_n)
      (wr1 && init_busy) |=> $stable(imr));

endmodule

// File: tb/test_intc_cmd_decoder.sv
module test_intc_cmd_decoder;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic [7:0] irr_in = '0;
   logic       poll_valid = 1'b0;
   logic [2:0] poll_line = '0;
   logic       ack_valid = 1'b0;
   logic [2:0] ack_line = '0;
   logic [7:0] imr, isr, vec_base;
   logic [2:0] rot_base;
   logic       init_busy, single_mode, nested_mode, auto_eoi;
   logic       special_mask, rot_on_aeoi, irr_flush, level_unsup;

   int n_checks = 0;
   int n_fail   = 0;

   always #10 clk = ~clk;   // 50 MHz

   intc_cmd_decoder i_intc_cmd_decoder (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .irr_in(irr_in), .poll_valid(poll_valid),
      .poll_line(poll_line), .ack_valid(ack_valid), .ack_line(ack_line),
      .imr(imr), .isr(isr), .rot_base(rot_base), .vec_base(vec_base),
      .init_busy(init_busy), .single_mode(single_mode), .nested_mode(nested_mode),
      .auto_eoi(auto_eoi), .special_mask(special_mask), .rot_on_aeoi(rot_on_aeoi),
      .irr_flush(irr_flush), .level_unsup(level_unsup)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic a, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; addr = a;
      #2 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic ack(input logic [2:0] l);
      @(negedge clk);
      ack_valid = 1'b1; ack_line = l;
      @(negedge clk);
      ack_valid = 1'b0;
   endtask

   // single mode, fourth byte needed, vector 0x20, then mode byte
   task automatic quick_init(input logic [7:0] mode_byte);
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h20);
      wr(1'b1, mode_byte);
   endtask

   task automatic t_reset;
      check("R1", "imr", imr, 0);
      check("R1", "isr", isr, 0);
      check("R1", "rot_base", rot_base, 0);
      check("R1", "vec_base", vec_base, 0);
      check("R1", "flags", {init_busy, single_mode, nested_mode, auto_eoi,
                            special_mask, rot_on_aeoi, irr_flush, level_unsup}, 0);
      check("R1", "rdata idle", rdata, 0);
   endtask

   task automatic t_init_cascaded;
      logic [7:0] d;
      wr(1'b1, 8'hA5);
      check("R6", "mask before init", imr, 8'hA5);
      wr(1'b0, 8'h11);
      check("R2", "busy after start", init_busy, 1);
      check("R2", "mask cleared", imr, 0);
      check("R2", "flush pulse", irr_flush, 1);
      check("R2", "no level pulse", level_unsup, 0);
      check("R2", "single latched", single_mode, 0);
      @(negedge clk);
      check("R2", "flush one cycle", irr_flush, 0);
      wr(1'b1, 8'h45);
      check("R3", "vector base", vec_base, 8'h40);
      check("R14", "mask untouched by init byte", imr, 0);
      check("R3", "cascade step still busy", init_busy, 1);
      wr(1'b1, 8'h04);
      check("R4", "mode step still busy", init_busy, 1);
      wr(1'b1, 8'h12);
      check("R5", "sequence done", init_busy, 0);
      check("R5", "nested", nested_mode, 1);
      check("R5", "auto eoi", auto_eoi, 1);
      check("R14", "mask after sequence", imr, 0);
      rd(1'b1, d);
      check("R6", "mask read", d, 0);
   endtask

   task automatic t_init_short;
      wr(1'b0, 8'h1A);
      check("R2", "level pulse", level_unsup, 1);
      check("R2", "single latched", single_mode, 1);
      check("R2", "auto eoi cleared", auto_eoi, 0);
      check("R2", "nested cleared", nested_mode, 0);
      wr(1'b1, 8'h2F);
      check("R3", "vector masked", vec_base, 8'h28);
      check("R3", "single no fourth byte ends", init_busy, 0);
      wr(1'b0, 8'h13);
      wr(1'b1, 8'h08);
      check("R3", "single with fourth byte goes to mode", init_busy, 1);
      wr(1'b1, 8'h00);
      check("R5", "done", init_busy, 0);
      check("R5", "auto eoi off", auto_eoi, 0);
      wr(1'b0, 8'h10);
      wr(1'b1, 8'h00);
      wr(1'b1, 8'h00);
      check("R4", "cascade without fourth byte ends", init_busy, 0);
   endtask

   task automatic t_mask;
      logic [7:0] d;
      wr(1'b1, 8'h5A);
      check("R6", "mask load", imr, 8'h5A);
      rd(1'b1, d);
      check("R6", "mask read", d, 8'h5A);
   endtask

   task automatic t_read_ctl;
      logic [7:0] d;
      quick_init(8'h00);
      irr_in = 8'h3C;
      ack(3'd1);
      rd(1'b0, d);
      check("R7", "default reads IRR", d, 8'h3C);
      wr(1'b0, 8'h0B);
      rd(1'b0, d);
      check("R7", "ISR selected", d, 8'h02);
      wr(1'b0, 8'h09);
      rd(1'b0, d);
      check("R7", "bit1 clear keeps select", d, 8'h02);
      wr(1'b0, 8'h0A);
      rd(1'b0, d);
      check("R7", "IRR selected", d, 8'h3C);
      wr(1'b0, 8'h68);
      check("R7", "special mask on", special_mask, 1);
      wr(1'b0, 8'h28);
      check("R7", "bits 6:5 = 1 no change", special_mask, 1);
      wr(1'b0, 8'h48);
      check("R7", "special mask off", special_mask, 0);
   endtask

   task automatic t_poll;
      logic [7:0] d;
      quick_init(8'h00);
      irr_in = 8'h21;
      poll_valid = 1'b1; poll_line = 3'd5;
      wr(1'b0, 8'h0C);
      rd(1'b0, d);
      check("R8", "poll winner", d, 8'h85);
      rd(1'b0, d);
      check("R8", "poll disarmed", d, 8'h21);
      poll_valid = 1'b0;
      wr(1'b0, 8'h0C);
      rd(1'b0, d);
      check("R8", "poll no winner", d, 8'h00);
      rd(1'b0, d);
      check("R8", "poll disarmed again", d, 8'h21);
   endtask

   task automatic t_ack_aeoi;
      quick_init(8'h02);
      check("R5", "auto eoi set", auto_eoi, 1);
      wr(1'b0, 8'h80);
      check("R12", "rotate on aeoi set", rot_on_aeoi, 1);
      ack(3'd3);
      check("R9", "aeoi ack leaves isr", isr, 0);
      check("R9", "aeoi ack rotates", rot_base, 4);
      ack(3'd7);
      check("R9", "aeoi ack wraps", rot_base, 0);
      wr(1'b0, 8'h00);
      check("R12", "rotate on aeoi cleared", rot_on_aeoi, 0);
      ack(3'd5);
      check("R9", "no rotate when flag clear", rot_base, 0);
   endtask

   task automatic t_eoi;
      quick_init(8'h00);
      ack(3'd2); ack(3'd5); ack(3'd6);
      check("R9", "acks set isr", isr, 8'h64);
      wr(1'b0, 8'h20);
      check("R10", "non-specific eoi", isr, 8'h60);
      check("R10", "base unchanged", rot_base, 0);
      wr(1'b0, 8'hC5);
      check("R11", "set base", rot_base, 6);
      check("R11", "set base leaves isr", isr, 8'h60);
      wr(1'b0, 8'hA0);
      check("R10", "rotated eoi clears line 6", isr, 8'h20);
      check("R10", "rotated eoi base", rot_base, 7);
      wr(1'b0, 8'h65);
      check("R11", "specific eoi", isr, 0);
      wr(1'b0, 8'h20);
      check("R13", "empty eoi isr", isr, 0);
      check("R13", "empty eoi base", rot_base, 7);
      wr(1'b0, 8'hA0);
      check("R13", "empty rotating eoi base", rot_base, 7);
      ack(3'd3); ack(3'd1);
      wr(1'b0, 8'hE3);
      check("R11", "specific rotating eoi isr", isr, 8'h02);
      check("R11", "specific rotating eoi base", rot_base, 4);
      wr(1'b0, 8'h40);
      check("R11", "opcode 2 isr", isr, 8'h02);
      check("R11", "opcode 2 base", rot_base, 4);
      wr(1'b0, 8'h13);
      check("R2", "start clears isr", isr, 0);
      check("R2", "start clears base", rot_base, 0);
   endtask

   initial begin
      #(20 * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_init_cascaded();
      t_init_short();
      t_mask();
      t_read_ctl();
      t_poll();
      t_ack_aeoi();
      t_eoi();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

endmodule